// File: doc/BRIEF.md
# Burst-Capable Processor Bus Cycle Sequencer

This block sits between a processor core and its external bus. It takes one internal read or write request at a time and turns it into an external bus cycle. A cycle starts with an address clock, in which an active-low strobe marks the address as valid. One or more data clocks follow, until the external side signals that the transfer is complete. Reads can be single transfers or four-word bursts. A burst uses its own completion handshake for each word, and a last-transfer indication warns the external side that the next burst handshake ends the cycle.

Each byte lane carries one parity bit. On writes the block drives even parity for each lane. On reads it checks the parity of every lane that is enabled and flags a mismatch for one clock. An external master can force the block off the bus with an active-low back-off input. The sequencer then floats all of its drivers and later repeats the interrupted cycle from its address clock. A separate address-hold input floats only the address drivers and does not stop the cycle. Tri-state control appears as output-enable signals, and the pads are built outside the block.

Top module: `pbus_seq`

## Requirements
- R1: After reset the sequencer is idle. `ads_n`, `blast_n` and `pchk_n` are high, `ctl_oe`, `addr_oe` and `data_oe` are low, and `done` and `rd_valid` are low.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the next clock `ads_n` is low for exactly one clock and address, byte enables and cycle type are driven (`bus_wr` 1 = write). Data clocks follow. With no wait states a single transfer takes two clocks, and `done` pulses high in the clock after the completing edge.
- R3: A single transfer completes only on an edge where `rdy_n` is low in a data clock. `brdy_n` has no effect on it. While `rdy_n` stays high the data clocks repeat with unchanged outputs.
- R4: A read requested as a burst moves four words. Each word completes on an edge where `brdy_n` is low, and `rdy_n` has no effect. Word k uses the address with bits [3:2] equal to (start bits [3:2] + k) mod 4. With no wait states the cycle lasts five clocks.
- R5: `blast_n` is low only during data clocks of the final transfer: every data clock of a single transfer, and the fourth word of a burst.
- R6: In the data clocks of a write, `data_oe` is high, `data_out` carries the request data, and `par_out[n]` is the XOR of `data_out[8n+7:8n]`, which gives each lane even parity. A write requested as a burst runs as a single transfer.
- R7: After each completed read transfer, `pchk_n` is low for exactly one clock if some lane n with `bus_be[n]` = 1 has an XOR of `data_in[8n+7:8n]` and `par_in[n]` equal to 1. Lanes with their enable low are ignored.
- R8: After each completed read transfer, `rd_valid` is high for one clock and `rd_data` holds the `data_in` value sampled at the completing edge.
- R9: If `boff_n` is low at an edge during an address or data clock, then from the next clock `ctl_oe`, `addr_oe` and `data_oe` are low and `ads_n` and `blast_n` are high. The block stays off the bus until `boff_n` is sampled high. It then repeats the cycle from its address clock with the same address, type and data, starting a burst again from its first word.
- R10: `rdy_n` and `brdy_n` sampled at an edge where `boff_n` is low complete nothing. No `done`, no `rd_valid` and no parity flag follow.
- R11: `ahold` sampled high at an edge forces `addr_oe` low in the next clock. The cycle keeps running and the control drivers stay enabled.
- R12: `req_ready` is high only while the sequencer is idle and `boff_n` is high. A request presented at any other time is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Request accepted this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Ask for a four-word burst (reads only) |
| req_mio | input | 1 | 1 = memory space, 0 = I/O space |
| req_dc | input | 1 | 1 = data cycle, 0 = control cycle |
| req_addr | input | 30 | Word address, bits 31:2 |
| req_be | input | 4 | Byte-lane enables |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read word returned |
| rd_data | output | 32 | Returned read word |
| done | output | 1 | Cycle complete pulse |
| bus_addr | output | 30 | External address, bits 31:2 |
| bus_be | output | 4 | External byte enables, lane n = bits 8n+7:8n |
| ads_n | output | 1 | Address strobe, active low |
| bus_wr | output | 1 | Cycle direction, 1 = write |
| bus_mio | output | 1 | Memory or I/O space |
| bus_dc | output | 1 | Data or control cycle |
| blast_n | output | 1 | Final transfer indication, active low |
| addr_oe | output | 1 | Address driver enable |
| ctl_oe | output | 1 | Control and strobe driver enable |
| data_oe | output | 1 | Data and parity driver enable |
| data_out | output | 32 | Write data to the bus |
| par_out | output | 4 | Write parity, one bit per lane |
| data_in | input | 32 | Read data from the bus |
| par_in | input | 4 | Read parity, one bit per lane |
| rdy_n | input | 1 | Single-transfer completion, active low |
| brdy_n | input | 1 | Burst word completion, active low |
| boff_n | input | 1 | Back-off, active low |
| ahold | input | 1 | Address hold, floats address drivers |
| pchk_n | output | 1 | Read parity error flag, active low |

## Verification
The bench drives `rdy_n` and `brdy_n` low where they must not count. `brdy_n` is asserted during a single transfer and `rdy_n` during a burst, so a design that mixes up the two handshakes would finish cycles early. Back-off is applied in the address clock and again mid-burst in the same clock as a burst handshake. A design that kept the floated clocks' handshake would report a word or `done` that never happened, and one that resumed rather than restarted would return too few words or the wrong address. Parity errors are placed once in an enabled lane and once in a disabled lane, which exposes a checker that ignores the byte enables or holds its flag too long. A request offered while back-off is low must not be accepted, and address-hold must float only the address and must not stall the cycle.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    // phase of the external bus cycle
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_HELD = 2'd3
    } phase_t;
endpackage

// File: rtl/pbus_lane_parity.sv
module pbus_lane_parity #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0] data,
    output logic [LANES-1:0]   par
);
    // even parity bit for each byte lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign par[g] = ^data[8*g +: 8];
    end
endmodule

// File: rtl/pbus_ctl.sv
module pbus_ctl
    import pbus_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LANES = 4,
    parameter int BEATS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic               req_burst,
    input  logic               req_mio,
    input  logic               req_dc,
    input  logic [AW-1:2]      req_addr,
    input  logic [LANES-1:0]   req_be,
    input  logic [8*LANES-1:0] req_wdata,
    input  logic [8*LANES-1:0] data_in,
    input  logic [LANES-1:0]   lane_bad,
    input  logic               rdy_n,
    input  logic               brdy_n,
    input  logic               boff_n,
    input  logic               ahold,
    output logic [AW-1:2]      bus_addr,
    output logic [LANES-1:0]   bus_be,
    output logic               ads_n,
    output logic               bus_wr,
    output logic               bus_mio,
    output logic               bus_dc,
    output logic               blast_n,
    output logic               addr_oe,
    output logic               ctl_oe,
    output logic               data_oe,
    output logic [8*LANES-1:0] data_out,
    output logic               rd_valid,
    output logic [8*LANES-1:0] rd_data,
    output logic               pchk_n,
    output logic               done
);
    localparam int DW = 8 * LANES;
    localparam int BW = $clog2(BEATS);
    localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

    typedef struct packed {
        phase_t          phase;
        logic [BW-1:0]   beat;
        logic [AW-1:2]   addr;
        logic [LANES-1:0] be;
        logic            wr;
        logic            burst;
        logic            mio;
        logic            dc;
        logic [DW-1:0]   wdata;
        logic [DW-1:0]   rdata;
        logic            rvalid;
        logic            pchk;
        logic            fin;
        logic            ahold;
    } seq_t;

    seq_t st_d, st_q;
    logic last_xfer;
    logic xfer_end;

    assign last_xfer = !st_q.burst || (st_q.beat == LAST_BEAT);
    assign xfer_end  = st_q.burst ? !brdy_n : !rdy_n;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.pchk   = 1'b0;
        st_d.fin    = 1'b0;
        st_d.ahold  = ahold;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid && boff_n) begin
                    st_d.phase = PH_ADDR;
                    st_d.beat  = '0;
                    st_d.addr  = req_addr;
                    st_d.be    = req_be;
                    st_d.wr    = req_write;
                    st_d.burst = req_burst && !req_write;
                    st_d.mio   = req_mio;
                    st_d.dc    = req_dc;
                    st_d.wdata = req_wdata;
                end
            end
            PH_ADDR: begin
                st_d.phase = boff_n ? PH_DATA : PH_HELD;
            end
            PH_DATA: begin
                if (!boff_n) begin
                    st_d.phase = PH_HELD;
                end else if (xfer_end) begin
                    if (!st_q.wr) begin
                        st_d.rvalid = 1'b1;
                        st_d.rdata  = data_in;
                        st_d.pchk   = |(st_q.be & lane_bad);
                    end
                    if (last_xfer) begin
                        st_d.phase = PH_IDLE;
                        st_d.fin   = 1'b1;
                    end else begin
                        st_d.beat = st_q.beat + 1'b1;
                    end
                end
            end
            default: begin
                if (boff_n) begin
                    st_d.phase = PH_ADDR;
                    st_d.beat  = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.phase == PH_IDLE) && boff_n;
    assign ctl_oe    = (st_q.phase == PH_ADDR) || (st_q.phase == PH_DATA);
    assign addr_oe   = ctl_oe && !st_q.ahold;
    assign data_oe   = (st_q.phase == PH_DATA) && st_q.wr;
    assign ads_n     = (st_q.phase != PH_ADDR);
    assign blast_n   = !((st_q.phase == PH_DATA) && last_xfer);
    assign bus_addr  = {st_q.addr[AW-1:BW+2], st_q.addr[BW+1:2] + st_q.beat};
    assign bus_be    = st_q.be;
    assign bus_wr    = st_q.wr;
    assign bus_mio   = st_q.mio;
    assign bus_dc    = st_q.dc;
    assign data_out  = st_q.wdata;
    assign rd_valid  = st_q.rvalid;
    assign rd_data   = st_q.rdata;
    assign pchk_n    = !st_q.pchk;
    assign done      = st_q.fin;

    AST_ADS_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> ads_n);  // R2
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !ads_n);  // R12
    AST_BLAST_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.phase == PH_DATA) && !blast_n && boff_n && xfer_end) |=> done);  // R5
    AST_BOFF_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && !boff_n) |=> (!ctl_oe && !addr_oe && !data_oe));  // R9
    AST_HELD_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_HELD) |=> ($stable(st_q.addr) && $stable(st_q.wdata)));  // R9
    AST_BOFF_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.phase == PH_DATA) && !boff_n) |=> (!rd_valid && !done && pchk_n));  // R10
    AST_PCHK_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !pchk_n |-> rd_valid);  // R7
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq #(
    parameter int AW    = 32,
    parameter int LANES = 4,
    parameter int BEATS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic               req_burst,
    input  logic               req_mio,
    input  logic               req_dc,
    input  logic [AW-1:2]      req_addr,
    input  logic [LANES-1:0]   req_be,
    input  logic [8*LANES-1:0] req_wdata,
    output logic               rd_valid,
    output logic [8*LANES-1:0] rd_data,
    output logic               done,
    output logic [AW-1:2]      bus_addr,
    output logic [LANES-1:0]   bus_be,
    output logic               ads_n,
    output logic               bus_wr,
    output logic               bus_mio,
    output logic               bus_dc,
    output logic               blast_n,
    output logic               addr_oe,
    output logic               ctl_oe,
    output logic               data_oe,
    output logic [8*LANES-1:0] data_out,
    output logic [LANES-1:0]   par_out,
    input  logic [8*LANES-1:0] data_in,
    input  logic [LANES-1:0]   par_in,
    input  logic               rdy_n,
    input  logic               brdy_n,
    input  logic               boff_n,
    input  logic               ahold,
    output logic               pchk_n
);
    logic [LANES-1:0] in_par;
    logic [LANES-1:0] lane_bad;

    pbus_lane_parity #(.LANES(LANES)) u_wpar (
        .data (data_out),
        .par  (par_out)
    );

    pbus_lane_parity #(.LANES(LANES)) u_rpar (
        .data (data_in),
        .par  (in_par)
    );

    assign lane_bad = in_par ^ par_in;

    pbus_ctl #(.AW(AW), .LANES(LANES), .BEATS(BEATS)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_burst (req_burst),
        .req_mio   (req_mio),
        .req_dc    (req_dc),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .data_in   (data_in),
        .lane_bad  (lane_bad),
        .rdy_n     (rdy_n),
        .brdy_n    (brdy_n),
        .boff_n    (boff_n),
        .ahold     (ahold),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .ads_n     (ads_n),
        .bus_wr    (bus_wr),
        .bus_mio   (bus_mio),
        .bus_dc    (bus_dc),
        .blast_n   (blast_n),
        .addr_oe   (addr_oe),
        .ctl_oe    (ctl_oe),
        .data_oe   (data_oe),
        .data_out  (data_out),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .pchk_n    (pchk_n),
        .done      (done)
    );
endmodule

// File: tb/sim_pbus_seq.sv
module sim_pbus_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
    logic        req_mio = 1'b1, req_dc = 1'b1;
    logic [31:2] req_addr = '0;
    logic [3:0]  req_be = 4'hF;
    logic [31:0] req_wdata = '0;
    logic [31:0] data_in = '0;
    logic [3:0]  par_in = '0;
    logic        rdy_n = 1'b1, brdy_n = 1'b1, boff_n = 1'b1, ahold = 1'b0;
    logic        req_ready, rd_valid, done, ads_n, bus_wr, bus_mio, bus_dc;
    logic        blast_n, addr_oe, ctl_oe, data_oe, pchk_n;
    logic [31:0] rd_data, data_out;
    logic [31:2] bus_addr;
    logic [3:0]  bus_be, par_out;

    pbus_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_burst(req_burst), .req_mio(req_mio),
        .req_dc(req_dc), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .bus_addr(bus_addr), .bus_be(bus_be), .ads_n(ads_n),
        .bus_wr(bus_wr), .bus_mio(bus_mio), .bus_dc(bus_dc),
        .blast_n(blast_n), .addr_oe(addr_oe), .ctl_oe(ctl_oe),
        .data_oe(data_oe), .data_out(data_out), .par_out(par_out),
        .data_in(data_in), .par_in(par_in), .rdy_n(rdy_n), .brdy_n(brdy_n),
        .boff_n(boff_n), .ahold(ahold), .pchk_n(pchk_n)
    );

    always #5 clk = ~clk;

    int vecs = 0;
    int errs = 0;
    bit finished = 1'b0;
    string scen = "R1";
    logic [3:0] corrupt = 4'h0;
    int dcount = 0;

    // behavioural reference: phase 0 idle, 1 address, 2 data, 3 floated
    int          m_ph = 0;
    int          m_beat = 0;
    logic [31:0] m_addr = '0;
    logic [3:0]  m_be = '0;
    logic        m_wr = 0, m_bst = 0, m_mio = 0, m_dc = 0;
    logic [31:0] m_wd = '0, m_rd = '0;
    logic        m_rdv = 0, m_pchk = 0, m_done = 0, m_ah = 0;

    function automatic logic [3:0] even_par(input logic [31:0] d);
        logic [3:0] p;
        for (int n = 0; n < 4; n++) p[n] = ^d[8*n +: 8];
        return p;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_beat = 0; m_rdv = 0; m_pchk = 0; m_done = 0; m_ah = 0;
            m_addr = '0; m_be = '0; m_wr = 0; m_bst = 0; m_mio = 0; m_dc = 0;
            m_wd = '0; m_rd = '0;
        end else begin
            m_rdv = 0; m_pchk = 0; m_done = 0;
            if (m_ph == 0) begin
                if (req_valid && boff_n) begin
                    m_ph = 1; m_beat = 0;
                    m_addr = {req_addr, 2'b00}; m_be = req_be; m_wr = req_write;
                    m_bst = req_burst && !req_write; m_mio = req_mio; m_dc = req_dc;
                    m_wd = req_wdata;
                end
            end else if (m_ph == 1) begin
                m_ph = boff_n ? 2 : 3;
            end else if (m_ph == 2) begin
                if (!boff_n) m_ph = 3;
                else if (m_bst ? !brdy_n : !rdy_n) begin
                    if (!m_wr) begin
                        m_rdv = 1; m_rd = data_in;
                        m_pchk = |(m_be & (even_par(data_in) ^ par_in));
                    end
                    if (!m_bst || m_beat == 3) begin m_done = 1; m_ph = 0; end
                    else m_beat++;
                end
            end else begin
                if (boff_n) begin m_ph = 1; m_beat = 0; end
            end
            m_ah = ahold;
        end
    end

    task automatic cmp(input string sig, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
        if (got !== exp) begin
            errs++;
            $display("FAIL %s [%s] %s: got %h expected %h at %0t", req, scen, sig, got, exp, $time);
        end
    endtask

    task automatic check_all();
        logic busy;
        logic [31:0] ea;
        busy = (m_ph == 1) || (m_ph == 2);
        vecs++;
        cmp("ads_n",    "R2",  {31'b0, ads_n},   {31'b0, m_ph != 1});
        cmp("blast_n",  "R5",  {31'b0, blast_n}, {31'b0, !(m_ph == 2 && (!m_bst || m_beat == 3))});
        cmp("ctl_oe",   "R9",  {31'b0, ctl_oe},  {31'b0, busy});
        cmp("addr_oe",  "R11", {31'b0, addr_oe}, {31'b0, busy && !m_ah});
        cmp("data_oe",  "R6",  {31'b0, data_oe}, {31'b0, m_ph == 2 && m_wr});
        cmp("done",     "R2",  {31'b0, done},    {31'b0, m_done});
        cmp("rd_valid", "R8",  {31'b0, rd_valid},{31'b0, m_rdv});
        cmp("pchk_n",   "R7",  {31'b0, pchk_n},  {31'b0, !m_pchk});
        cmp("req_ready","R12", {31'b0, req_ready},{31'b0, m_ph == 0 && boff_n});
        if (busy) begin
            ea = m_addr;
            ea[3:2] = m_addr[3:2] + 2'(m_beat);
            cmp("bus_addr", "R4", {bus_addr, 2'b00}, ea);
            cmp("bus_be",   "R2", {28'b0, bus_be}, {28'b0, m_be});
            cmp("bus_type", "R2", {29'b0, bus_wr, bus_mio, bus_dc}, {29'b0, m_wr, m_mio, m_dc});
        end
        if (m_ph == 2 && m_wr) begin
            cmp("data_out", "R6", data_out, m_wd);
            cmp("par_out",  "R6", {28'b0, par_out}, {28'b0, even_par(m_wd)});
        end
        if (m_rdv) cmp("rd_data", "R8", rd_data, m_rd);
    endtask

    task automatic cyc(input logic v, input logic rdy, input logic brdy,
                       input logic boff, input logic ah);
        @(negedge clk);
        check_all();
        req_valid = v; rdy_n = rdy; brdy_n = brdy; boff_n = boff; ahold = ah;
        dcount++;
        data_in = 32'h5A3C_0F11 ^ (dcount * 32'h0102_0408);
        par_in = even_par(data_in) ^ corrupt;
    endtask

    task automatic setreq(input logic wr, input logic bst, input logic [31:0] a,
                          input logic [3:0] be, input logic [31:0] wd);
        req_write = wr; req_burst = bst; req_addr = a[31:2]; req_be = be;
        req_wdata = wd; req_mio = a[4]; req_dc = !a[5];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 1, 1, 1, 0);
    endtask

    initial begin
        // R1: reset state
        scen = "R1";
        repeat (3) cyc(0, 1, 1, 1, 0);
        @(negedge clk);
        vecs++;
        cmp("reset ads_n/blast_n/pchk_n", "R1", {29'b0, ads_n, blast_n, pchk_n}, 32'h7);
        cmp("reset oe", "R1", {29'b0, ctl_oe, addr_oe, data_oe}, 32'h0);
        cmp("reset done/rd_valid", "R1", {30'b0, done, rd_valid}, 32'h0);
        rst_n = 1'b1;
        idle(2);

        // R2: zero-wait single read
        scen = "R2";
        setreq(0, 0, 32'h0000_1004, 4'hF, 0);
        cyc(1, 1, 1, 1, 0); cyc(0, 0, 1, 1, 0); cyc(0, 0, 1, 1, 0); idle(2);

        // R3: single read with waits, brdy_n low must not end it
        scen = "R3";
        setreq(0, 0, 32'h0000_2008, 4'h3, 0);
        cyc(1, 1, 1, 1, 0); cyc(0, 1, 0, 1, 0); cyc(0, 1, 0, 1, 0);
        @(negedge clk);
        vecs++;
        cmp("done during wait", "R3", {31'b0, done}, 32'h0);
        cmp("ads_n during wait", "R3", {31'b0, ads_n}, 32'h1);
        cyc(0, 1, 0, 1, 0); cyc(0, 0, 1, 1, 0); idle(2);

        // R6: single write, parity out
        scen = "R6";
        setreq(1, 0, 32'h0000_3010, 4'hF, 32'h8001_7F03);
        cyc(1, 1, 1, 1, 0); cyc(0, 1, 1, 1, 0); cyc(0, 1, 1, 1, 0); cyc(0, 0, 1, 1, 0); idle(1);
        // burst write request runs as a single transfer
        setreq(1, 1, 32'h0000_3020, 4'h5, 32'hFFFF_0001);
        cyc(1, 1, 1, 1, 0); cyc(0, 0, 1, 1, 0); cyc(0, 0, 1, 1, 0); idle(2);

        // R4/R5: zero-wait burst from offset 2, rdy_n low ignored
        scen = "R4";
        setreq(0, 1, 32'h0000_4008, 4'hF, 0);
        cyc(1, 0, 1, 1, 0);
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 0);
        idle(2);
        // burst with wait states between words
        scen = "R5";
        setreq(0, 1, 32'h0000_400C, 4'hF, 0);
        cyc(1, 1, 1, 1, 0); cyc(0, 1, 1, 1, 0);
        for (int i = 0; i < 4; i++) begin cyc(0, 1, 1, 1, 0); cyc(0, 1, 0, 1, 0); end
        idle(2);

        // R7: parity error in enabled lane, then in disabled lane
        scen = "R7";
        corrupt = 4'h2;
        setreq(0, 0, 32'h0000_5000, 4'h2, 0);
        cyc(1, 1, 1, 1, 0); cyc(0, 0, 1, 1, 0); cyc(0, 0, 1, 1, 0); idle(1);
        setreq(0, 0, 32'h0000_5004, 4'hD, 0);
        cyc(1, 1, 1, 1, 0); cyc(0, 0, 1, 1, 0); cyc(0, 0, 1, 1, 0); idle(1);
        @(negedge clk);
        vecs++;
        cmp("pchk_n disabled lane", "R7", {31'b0, pchk_n}, 32'h1);
        corrupt = 4'h0;
        idle(1);

        // R9/R10: back-off mid burst together with brdy_n
        scen = "R10";
        setreq(0, 1, 32'h0000_6000, 4'hF, 0);
        cyc(1, 1, 1, 1, 0); cyc(0, 1, 0, 1, 0); cyc(0, 1, 0, 1, 0);
        cyc(0, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0);
        @(negedge clk);
        vecs++;
        cmp("rd_valid after boff", "R10", {31'b0, rd_valid}, 32'h0);
        cmp("ctl_oe after boff", "R9", {31'b0, ctl_oe}, 32'h0);
        cyc(0, 1, 0, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 1, 0, 1, 0);
        idle(2);
        // back-off in the address clock of a write
        scen = "R9";
        setreq(1, 0, 32'h0000_6100, 4'hF, 32'h1234_5678);
        cyc(1, 1, 1, 1, 0); cyc(0, 0, 1, 0, 0); cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 1, 1, 0); cyc(0, 0, 1, 1, 0); cyc(0, 0, 1, 1, 0); idle(2);

        // R11: address hold floats only the address
        scen = "R11";
        setreq(0, 0, 32'h0000_7004, 4'hF, 0);
        cyc(1, 1, 1, 1, 1); cyc(0, 1, 1, 1, 1); cyc(0, 1, 1, 1, 0);
        cyc(0, 0, 1, 1, 0); idle(2);

        // R12: request while back-off low is not taken
        scen = "R12";
        setreq(0, 0, 32'h0000_8000, 4'hF, 0);
        cyc(1, 1, 1, 0, 0); cyc(1, 1, 1, 0, 0);
        @(negedge clk);
        vecs++;
        cmp("ads_n while boff", "R12", {31'b0, ads_n}, 32'h1);
        cyc(0, 1, 1, 1, 0); idle(3);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errs++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule